// File: doc/BRIEF.md
# Padded Vertex Count Calculator

This block turns a raw vertex count into a padded count that a thread dispatcher can divide and take modulus by cheaply. The padded count always has the form (2m+1)·2^s with the odd factor 2m+1 taken from {1, 3, 5, 7, 9}. It is always a multiple of four and always strictly above the raw count. Besides the padded value, the block reports the exponent s and the odd-factor field m. Downstream logic can then do the division as one shift plus a small fixed-divisor step.

For counts of 32 and above, the choice depends only on the leading one of the count and the three bits just below it. Below 32, the result is the next multiple of four above the count. Every count pulse produces one result pulse exactly one clock later. Between pulses the outputs hold their last result.

Top module: `vtx_pad_calc`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_padded, out_shift and out_odd are all zero until the first accepted input.
- R2: out_valid is high in exactly the cycle after in_valid was high. The result in that cycle belongs to the count presented with that in_valid.
- R3: Every result satisfies out_padded == (2*out_odd + 1) << out_shift, with out_odd in 0..4 (0 for x1, 1 for x3, 2 for x5, 3 for x7, 4 for x9).
- R4: Every padded value is a multiple of 4 and strictly greater than its input count.
- R5: A count below 32 gives (count rounded down to a multiple of 4) + 4. A count of 0 gives 4 (shift 2, odd 0), and 31 gives 32 (shift 5, odd 0).
- R6: For counts of 32 or more, let p be the index of the highest set bit and n = p - 3. If the three bits below the leading one are 000, the result is 9·2^n with odd 4 and shift n. For example, 70 gives 72 with shift 3 and odd 4.
- R7: With the three bits below the leading one equal to 001, the result is 5·2^(n+1) (odd 2, shift n+1). For example, 72 gives 80.
- R8: With those bits equal to 01x, the result is 3·2^(n+2) (odd 1, shift n+2). For example, 80 gives 96.
- R9: With those bits equal to 10x, the result is 7·2^(n+1) (odd 3, shift n+1). For example, 96 gives 112.
- R10: With those bits equal to 11x, the result is 2^(n+4) (odd 0, shift n+4). The all-ones 32-bit count gives 2^32 with shift 32.
- R11: In a cycle without in_valid, out_padded, out_shift and out_odd keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Count is presented this cycle |
| in_count | input | CNT_W | Raw vertex count |
| out_valid | output | 1 | Result is valid this cycle |
| out_padded | output | CNT_W+1 | Padded count |
| out_shift | output | $clog2(CNT_W+1) | Power-of-two exponent of the padded count |
| out_odd | output | 3 | Odd-factor field m, factor is 2m+1 |

## Verification
The bench builds the block with the default CNT_W of 32. This makes the widest case reachable: an all-ones count yields a padded value of 2^32, which needs the extra output bit and a shift of 32. It also exercises a leading one at every index from 0 to 31, including the seam at 32 where the small-count rule hands over to the leading-bits rule. The expected value is the smallest number of the allowed form that is a multiple of four and above the count, found by search.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    // Odd multiplier selector: factor = 2*code + 1
    typedef enum logic [2:0] {
        ODD_X1 = 3'd0,
        ODD_X3 = 3'd1,
        ODD_X5 = 3'd2,
        ODD_X7 = 3'd3,
        ODD_X9 = 3'd4
    } odd_sel_e;

    // Counts whose leading one sits at or above this index use the leading-bits rule
    localparam int unsigned BIG_MSB = 5;
endpackage

// File: rtl/vpc_msb_find.sv
module vpc_msb_find #(
    parameter int unsigned CNT_W = 32,
    localparam int unsigned IDX_W = $clog2(CNT_W)
) (
    input  logic [CNT_W-1:0] count,
    output logic             any_set,
    output logic [IDX_W-1:0] msb_idx
);
    always_comb begin
        any_set = 1'b0;
        msb_idx = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (count[i]) begin
                any_set = 1'b1;
                msb_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpc_factor_sel.sv
module vpc_factor_sel #(
    parameter int unsigned CNT_W = 32,
    localparam int unsigned IDX_W = $clog2(CNT_W),
    localparam int unsigned SH_W  = $clog2(CNT_W + 1)
) (
    input  logic [CNT_W-1:0]       count,
    input  logic                   any_set,
    input  logic [IDX_W-1:0]       msb_idx,
    output logic [SH_W-1:0]        shift,
    output vpc_pkg::odd_sel_e      odd
);
    import vpc_pkg::*;

    logic             big;
    logic [IDX_W-1:0] n_low;
    logic [SH_W-1:0]  n_sh;
    logic [2:0]       follow3;
    logic [3:0]       quad;

    assign big     = any_set && (msb_idx >= IDX_W'(BIG_MSB));
    assign n_low   = msb_idx - IDX_W'(3);
    assign n_sh    = SH_W'(n_low);
    assign follow3 = 3'(count >> n_low);
    assign quad    = {1'b0, count[4:2]} + 4'd1;

    always_comb begin
        shift = '0;
        odd   = ODD_X1;
        if (big) begin
            casez (follow3)
                3'b000:  begin odd = ODD_X9; shift = n_sh;              end
                3'b001:  begin odd = ODD_X5; shift = n_sh + SH_W'(1);   end
                3'b01?:  begin odd = ODD_X3; shift = n_sh + SH_W'(2);   end
                3'b10?:  begin odd = ODD_X7; shift = n_sh + SH_W'(1);   end
                default: begin odd = ODD_X1; shift = n_sh + SH_W'(4);   end
            endcase
        end else begin
            // padded = 4 * quad, quad in 1..8
            case (quad)
                4'd1:    begin odd = ODD_X1; shift = SH_W'(2); end
                4'd2:    begin odd = ODD_X1; shift = SH_W'(3); end
                4'd3:    begin odd = ODD_X3; shift = SH_W'(2); end
                4'd4:    begin odd = ODD_X1; shift = SH_W'(4); end
                4'd5:    begin odd = ODD_X5; shift = SH_W'(2); end
                4'd6:    begin odd = ODD_X3; shift = SH_W'(3); end
                4'd7:    begin odd = ODD_X7; shift = SH_W'(2); end
                default: begin odd = ODD_X1; shift = SH_W'(5); end
            endcase
        end
    end
endmodule

// File: rtl/vpc_value_build.sv
module vpc_value_build #(
    parameter int unsigned CNT_W = 32,
    localparam int unsigned PAD_W = CNT_W + 1,
    localparam int unsigned SH_W  = $clog2(CNT_W + 1)
) (
    input  logic [SH_W-1:0]   shift,
    input  vpc_pkg::odd_sel_e odd,
    output logic [PAD_W-1:0]  padded
);
    logic [3:0] factor;

    assign factor = {3'(odd), 1'b1};
    assign padded = PAD_W'(factor) << shift;
endmodule

// File: rtl/vtx_pad_calc.sv
module vtx_pad_calc #(
    parameter int unsigned CNT_W = 32,
    localparam int unsigned PAD_W = CNT_W + 1,
    localparam int unsigned SH_W  = $clog2(CNT_W + 1),
    localparam int unsigned IDX_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] in_count,
    output logic             out_valid,
    output logic [PAD_W-1:0] out_padded,
    output logic [SH_W-1:0]  out_shift,
    output logic [2:0]       out_odd
);
    import vpc_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [PAD_W-1:0] pad;
        logic [SH_W-1:0]  sh;
        odd_sel_e         odd;
    } res_t;

    res_t state_d, state_q;

    logic             any_set;
    logic [IDX_W-1:0] msb_idx;
    logic [SH_W-1:0]  sel_shift;
    odd_sel_e         sel_odd;
    logic [PAD_W-1:0] sel_pad;

    vpc_msb_find #(.CNT_W(CNT_W)) u_msb (
        .count   (in_count),
        .any_set (any_set),
        .msb_idx (msb_idx)
    );

    vpc_factor_sel #(.CNT_W(CNT_W)) u_sel (
        .count   (in_count),
        .any_set (any_set),
        .msb_idx (msb_idx),
        .shift   (sel_shift),
        .odd     (sel_odd)
    );

    vpc_value_build #(.CNT_W(CNT_W)) u_val (
        .shift  (sel_shift),
        .odd    (sel_odd),
        .padded (sel_pad)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.pad = sel_pad;
            state_d.sh  = sel_shift;
            state_d.odd = sel_odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{vld: 1'b0, pad: '0, sh: '0, odd: ODD_X1};
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.vld;
    assign out_padded = state_q.pad;
    assign out_shift  = state_q.sh;
    assign out_odd    = 3'(state_q.odd);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_ODD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_odd <= 3'd4)); // R3
    AST_QUAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_padded[1:0] == 2'b00)); // R4
    AST_ABOVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_padded > {1'b0, $past(in_count)})); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_padded) && $stable(out_shift) && $stable(out_odd))); // R11
endmodule

// File: tb/sim_vtx_pad_calc.sv
`timescale 1ns/1ps
module sim_vtx_pad_calc;
    localparam int unsigned CNT_W = 32;
    localparam int unsigned PAD_W = CNT_W + 1;
    localparam int unsigned SH_W  = $clog2(CNT_W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [CNT_W-1:0] in_count = '0;
    logic             out_valid;
    logic [PAD_W-1:0] out_padded;
    logic [SH_W-1:0]  out_shift;
    logic [2:0]       out_odd;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vtx_pad_calc #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
        .out_valid(out_valid), .out_padded(out_padded),
        .out_shift(out_shift), .out_odd(out_odd)
    );

    // Smallest odd*2^k (odd in 1,3,5,7,9) that is a multiple of 4 and above c
    function automatic void ref_pad(input logic [CNT_W-1:0] c,
                                    output longint unsigned v,
                                    output int sh, output int od);
        longint unsigned best = 64'hFFFF_FFFF_FFFF_FFFF;
        sh = 0; od = 0;
        for (int k = 2; k <= CNT_W + 2; k++) begin
            for (int f = 1; f <= 9; f += 2) begin
                longint unsigned cand = longint'(f) << k;
                if (cand > longint'(c) && cand < best) begin
                    best = cand; sh = k; od = (f - 1) / 2;
                end
            end
        end
        v = best;
    endfunction

    function automatic string req_tag(input logic [CNT_W-1:0] c);
        int p = 0;
        logic [2:0] f3;
        if (c < 32) return "R5";
        for (int i = 0; i < CNT_W; i++) if (c[i]) p = i;
        f3 = 3'(c >> (p - 3));
        casez (f3)
            3'b000:  return "R6";
            3'b001:  return "R7";
            3'b01?:  return "R8";
            3'b10?:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check_res(input logic [CNT_W-1:0] c);
        longint unsigned ev;
        int es, eo;
        string tag = req_tag(c);
        ref_pad(c, ev, es, eo);
        checks++;
        if (!out_valid || longint'(out_padded) != ev || int'(out_shift) != es || int'(out_odd) != eo) begin
            failures++;
            $display("FAIL %s/R2 count=%0d actual vld=%0b pad=%0d sh=%0d odd=%0d expected vld=1 pad=%0d sh=%0d odd=%0d",
                     tag, c, out_valid, out_padded, out_shift, out_odd, ev, es, eo);
        end
        checks++;
        if (((longint'(out_odd) * 2 + 1) << out_shift) != longint'(out_padded) || out_odd > 4
            || out_padded[1:0] != 2'b00 || longint'(out_padded) <= longint'(c)) begin
            failures++;
            $display("FAIL R3/R4 count=%0d actual pad=%0d sh=%0d odd=%0d expected shape-consistent value above count",
                     c, out_padded, out_shift, out_odd);
        end
    endtask

    // Present one count, wait for its result, then one idle cycle
    task automatic single(input logic [CNT_W-1:0] c);
        logic [PAD_W-1:0] hp;
        logic [SH_W-1:0]  hs;
        logic [2:0]       ho;
        @(negedge clk); in_valid = 1'b1; in_count = c;
        @(negedge clk); in_valid = 1'b0; in_count = ~c;
        check_res(c);
        hp = out_padded; hs = out_shift; ho = out_odd;
        @(negedge clk);
        checks++;
        if (out_valid || out_padded != hp || out_shift != hs || out_odd != ho) begin
            failures++;
            $display("FAIL R11 idle count=%0d actual vld=%0b pad=%0d sh=%0d odd=%0d expected vld=0 pad=%0d sh=%0d odd=%0d",
                     ~c, out_valid, out_padded, out_shift, out_odd, hp, hs, ho);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] prev_c;
        bit prev_v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid || out_padded != '0 || out_shift != '0 || out_odd != '0) begin
            failures++;
            $display("FAIL R1 in reset actual vld=%0b pad=%0d sh=%0d odd=%0d expected all zero",
                     out_valid, out_padded, out_shift, out_odd);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid || out_padded != '0 || out_shift != '0 || out_odd != '0) begin
            failures++;
            $display("FAIL R1 after reset actual vld=%0b pad=%0d sh=%0d odd=%0d expected all zero",
                     out_valid, out_padded, out_shift, out_odd);
        end

        // Directed corners: R5 small counts, R6..R10 leading-bit classes
        single(32'd0);
        single(32'd3);
        single(32'd4);
        single(32'd17);
        single(32'd31);
        single(32'd32);          // R6 seam: 36
        single(32'd70);          // R6: 72
        single(32'd72);          // R7: 80
        single(32'd80);          // R8: 96
        single(32'd96);          // R9: 112
        single(32'd112);         // R10: 128
        single(32'h8000_0000);   // R6 at top
        single(32'hFFFF_FFFF);   // R10: 2^32

        // Back-to-back stream with random gaps, R2 latency under load
        prev_v = 0; prev_c = '0;
        for (int i = 0; i < 4000; i++) begin
            logic [CNT_W-1:0] c = $urandom >> ($urandom % 32);
            bit v = ($urandom % 4) != 0;
            @(negedge clk);
            if (prev_v) check_res(prev_c);
            else begin
                checks++;
                if (out_valid) begin
                    failures++;
                    $display("FAIL R2 stream actual vld=1 expected vld=0");
                end
            end
            in_valid = v; in_count = c;
            prev_v = v; prev_c = c;
        end
        @(negedge clk);
        if (prev_v) check_res(prev_c);
        in_valid = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule